// File: doc/BRIEF.md
# Banked Gray-Shade Palette

This block turns pixel codes into 4-bit gray shades for a monochrome LCD controller. It keeps a 16-entry table of shades. Software fills the table through two byte-wide registers on a small I/O bus. One register holds a pointer and a bank field. The other register holds the shade stored at that pointer. The pointer always covers the whole table as a flat 16-entry space, whatever the bank field says.

On the display side, a pixel code arrives on every clock together with a depth select. At 4 bits per pixel the code picks one of the 16 entries directly. At 2 bits per pixel the table acts as four banks of four entries. The bank field picks the bank and the two low pixel bits pick the entry inside it. The shade comes out of a register one clock after the pixel code. A 2-bit identification value comes from a tie-off input and reads back in the pointer register.

Top module: `gray_palette_lut`

## Requirements
- R1: After reset every table entry, the bank field and the pointer are zero, and `shade_out` is zero.
- R2: Register 4'hE reads as {bank[1:0], id_bits[1:0], pointer[3:0]}. A write to it loads bank from data bits 7:6 and the pointer from bits 3:0. Data bits 5:4 of the write are dropped, and bits 5:4 of a read always show `id_bits`.
- R3: Register 4'hF reads as {4'b0000, entry[pointer]}. A write to it stores data bits 3:0 into entry[pointer]. Data bits 7:4 of the write are dropped.
- R4: CPU reads and writes reach entry[pointer] for all 16 pointer values, whatever the bank field holds.
- R5: With `pix_mode`=0 (4 bits per pixel), `shade_out` equals entry[pix_val] one clock after `pix_val` is presented. The bank field has no effect.
- R6: With `pix_mode`=1 (2 bits per pixel), `shade_out` equals entry[bank*4 + pix_val[1:0]] one clock later. `pix_val[3:2]` is ignored.
- R7: A table write at a clock edge does not change the shade produced at that same edge. Lookups from the next edge onward see the new value.
- R8: `io_rdata` is zero unless `io_cs` and `io_re` are both high and `io_addr` is 4'hE or 4'hF. A write with `io_cs` low, or to any other address, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register select on the I/O bus |
| io_wdata | input | 8 | Write data |
| io_cs | input | 1 | Chip select |
| io_we | input | 1 | Write strobe, taken at the clock edge |
| io_re | input | 1 | Read enable for the combinational read path |
| io_rdata | output | 8 | Read data |
| id_bits | input | 2 | Identification tie-off, shown in the pointer register |
| pix_val | input | 4 | Pixel code from the fetch logic |
| pix_mode | input | 1 | Depth select: 0 = 4 bits per pixel, 1 = 2 bits per pixel |
| shade_out | output | 4 | Registered gray shade |

## Verification
Several properties are checked on every cycle:
- A data-register write lands in exactly the addressed entry.
- A pointer-register write loads the bank and pointer fields from the right bits.
- The ID field always mirrors the tie-off.
- The upper data bits and any unselected read return zero.
- The shade holds steady while its inputs and the table hold still.

The depth-dependent index mapping needs the bench's scenarios, which compare the shade against an independent model of the table:
- the bank field having no effect at 4 bits per pixel;
- the upper pixel bits being ignored at 2 bits per pixel;
- the ordering between a write and a lookup at the same edge.

// File: rtl/gpl_pkg.sv
package gpl_pkg;
  localparam int SHADE_W = 4;
  localparam int PTR_W   = 4;
  localparam int BANK_W  = 2;
  localparam int SUB_W   = PTR_W - BANK_W;
  localparam int ENTRIES = 1 << PTR_W;
  localparam int IOA_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int ID_W    = 2;
  localparam logic [IOA_W-1:0] REG_PTR  = 4'hE;
  localparam logic [IOA_W-1:0] REG_DATA = 4'hF;

  typedef enum logic {DEPTH_4BPP = 1'b0, DEPTH_2BPP = 1'b1} depth_e;

  // Table index for a pixel: flat at 4 bpp, bank-prefixed at 2 bpp.
  function automatic logic [PTR_W-1:0] pal_index(input depth_e depth,
                                                  input logic [BANK_W-1:0] bank,
                                                  input logic [PTR_W-1:0] pix);
    if (depth == DEPTH_2BPP) return {bank, pix[SUB_W-1:0]};
    return pix;
  endfunction

  // Pointer register image: bank on top, id in the middle, pointer below.
  function automatic logic [BYTE_W-1:0] ptr_word(input logic [BANK_W-1:0] bank,
                                                  input logic [ID_W-1:0] id,
                                                  input logic [PTR_W-1:0] ptr);
    return {bank, id, ptr};
  endfunction
endpackage

// File: rtl/gpl_regif.sv
module gpl_regif
  import gpl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IOA_W-1:0]   io_addr,
  input  logic [BYTE_W-1:0]  io_wdata,
  input  logic               io_cs,
  input  logic               io_we,
  input  logic               io_re,
  input  logic [ID_W-1:0]    id_bits,
  input  logic [SHADE_W-1:0] entry_at_ptr,
  output logic [BYTE_W-1:0]  io_rdata,
  output logic [BANK_W-1:0]  bank_q,
  output logic [PTR_W-1:0]   ptr_q,
  output logic               tbl_wr,
  output logic [SHADE_W-1:0] tbl_wval
);
  logic sel_ptr, sel_data, ptr_wr, rd_on;
  logic unused_wbits;

  assign sel_ptr      = io_cs && (io_addr == REG_PTR);
  assign sel_data     = io_cs && (io_addr == REG_DATA);
  assign ptr_wr       = sel_ptr && io_we;
  assign tbl_wr       = sel_data && io_we;
  assign tbl_wval     = io_wdata[SHADE_W-1:0];
  assign rd_on        = io_cs && io_re;
  assign unused_wbits = ^io_wdata[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      ptr_q  <= '0;
    end else if (ptr_wr) begin
      bank_q <= io_wdata[BYTE_W-1 -: BANK_W];
      ptr_q  <= io_wdata[PTR_W-1:0];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (rd_on && sel_ptr)       io_rdata = ptr_word(bank_q, id_bits, ptr_q);
    else if (rd_on && sel_data) io_rdata = {{(BYTE_W-SHADE_W){1'b0}}, entry_at_ptr};
  end

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (bank_q == $past(io_wdata[7:6]) && ptr_q == $past(io_wdata[3:0])));
  p_id_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && sel_ptr) |-> (io_rdata[5:4] == id_bits));
  p_data_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && sel_data) |-> (io_rdata[7:4] == 4'h0));
  p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_on && (sel_ptr || sel_data)) |-> (io_rdata == '0));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> ($stable(bank_q) && $stable(ptr_q)));
endmodule

// File: rtl/gpl_table.sv
module gpl_table
  import gpl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_idx,
  input  logic [SHADE_W-1:0]         wr_val,
  output logic [ENTRIES*SHADE_W-1:0] tbl_flat
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [SHADE_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      cell_q <= '0;
      else if (wr_en && (wr_idx == PTR_W'(e)))         cell_q <= wr_val;
    end
    assign tbl_flat[e*SHADE_W +: SHADE_W] = cell_q;
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl_flat[$past(wr_idx)*SHADE_W +: SHADE_W] == $past(wr_val)));
  p_table_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tbl_flat));
endmodule

// File: rtl/gpl_lookup.sv
module gpl_lookup
  import gpl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES*SHADE_W-1:0] tbl_flat,
  input  logic [BANK_W-1:0]          bank,
  input  logic [PTR_W-1:0]           pix,
  input  logic                       depth,
  output logic [SHADE_W-1:0]         shade_q
);
  logic [PTR_W-1:0] lut_idx;
  assign lut_idx = pal_index(depth_e'(depth), bank, pix);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shade_q <= '0;
    else        shade_q <= tbl_flat[lut_idx*SHADE_W +: SHADE_W];
  end

  p_bank_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == DEPTH_4BPP) |-> (lut_idx == pix));
endmodule

// File: rtl/gray_palette_lut.sv
module gray_palette_lut
  import gpl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_cs,
  input  logic        io_we,
  input  logic        io_re,
  output logic [7:0]  io_rdata,
  input  logic [1:0]  id_bits,
  input  logic [3:0]  pix_val,
  input  logic        pix_mode,
  output logic [3:0]  shade_out
);
  logic [BANK_W-1:0]          bank_q;
  logic [PTR_W-1:0]           ptr_q;
  logic                       tbl_wr;
  logic [SHADE_W-1:0]         tbl_wval;
  logic [ENTRIES*SHADE_W-1:0] tbl_flat;
  logic [SHADE_W-1:0]         entry_at_ptr;

  assign entry_at_ptr = tbl_flat[ptr_q*SHADE_W +: SHADE_W];

  gpl_regif u_regif (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_cs(io_cs), .io_we(io_we), .io_re(io_re), .id_bits(id_bits),
    .entry_at_ptr(entry_at_ptr), .io_rdata(io_rdata),
    .bank_q(bank_q), .ptr_q(ptr_q), .tbl_wr(tbl_wr), .tbl_wval(tbl_wval)
  );

  gpl_table u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(ptr_q),
    .wr_val(tbl_wval), .tbl_flat(tbl_flat)
  );

  gpl_lookup u_lookup (
    .clk(clk), .rst_n(rst_n), .tbl_flat(tbl_flat), .bank(bank_q),
    .pix(pix_val), .depth(pix_mode), .shade_q(shade_out)
  );

  // R7: with no write and steady lookup inputs, the shade does not move.
  p_shade_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pix_val) && $stable(pix_mode) && $stable(bank_q) && !$past(tbl_wr))
      |=> $stable(shade_out));
endmodule

// File: tb/gray_palette_lut_test.sv
module gray_palette_lut_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_cs = 1'b0, io_we = 1'b0, io_re = 1'b0;
  logic [7:0] io_rdata;
  logic [1:0] id_bits = 2'b10;
  logic [3:0] pix_val = '0;
  logic       pix_mode = 1'b0;
  logic [3:0] shade_out;

  int checks = 0, fails = 0;
  logic [3:0] m_tbl [16];
  logic [1:0] m_bank = '0;
  logic [3:0] m_ptr = '0;

  always #2 clk = ~clk;

  gray_palette_lut uut (.*);

  function automatic int exp_idx(input logic mode, input logic [1:0] bank, input logic [3:0] pix);
    if (mode) return int'(bank) * 4 + int'(pix) % 4;
    return int'(pix);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 4'hE) return {m_bank, id_bits, m_ptr};
    if (a == 4'hF) return {4'h0, m_tbl[m_ptr]};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_cs = cs; io_we = 1'b1;
    @(negedge clk);
    io_cs = 1'b0; io_we = 1'b0;
    if (cs && a == 4'hE) begin m_bank = d[7:6]; m_ptr = d[3:0]; end
    if (cs && a == 4'hF) m_tbl[m_ptr] = d[3:0];
  endtask

  task automatic cpu_rd(input string req, input logic [3:0] a);
    @(negedge clk);
    io_addr = a; io_cs = 1'b1; io_re = 1'b1;
    #1 chk(req, io_rdata, exp_rd(a));
    io_cs = 1'b0; io_re = 1'b0;
  endtask

  task automatic pix_chk(input string req, input logic mode, input logic [3:0] pix);
    @(negedge clk);
    pix_mode = mode; pix_val = pix;
    @(negedge clk);
    chk(req, {4'h0, shade_out}, {4'h0, m_tbl[exp_idx(mode, m_bank, pix)]});
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 shade", {4'h0, shade_out}, 8'h00);
    cpu_rd("R1 ptr reg", 4'hE);
    for (int i = 0; i < 16; i++) begin
      cpu_wr(4'hE, 8'(i));
      cpu_rd("R1 entry zero", 4'hF);
    end
    // fill table, data bits 7:4 set to show they are dropped (R3)
    for (int i = 0; i < 16; i++) begin
      cpu_wr(4'hE, 8'(i));
      cpu_wr(4'hF, {4'hA, 4'(15 - i)});
    end
    cpu_rd("R3 upper bits zero", 4'hF);
    // R2 id bits ignored on write, mirrored on read
    cpu_wr(4'hE, 8'b1001_0011);
    cpu_rd("R2 ptr reg readback", 4'hE);
    id_bits = 2'b01;
    cpu_rd("R2 id follows input", 4'hE);
    // R4 flat CPU access under every bank
    for (int b = 0; b < 4; b++) begin
      cpu_wr(4'hE, {2'(b), 2'b00, 4'(12 - b)});
      cpu_wr(4'hF, 8'(b + 3));
      cpu_rd("R4 flat access", 4'hF);
    end
    // R5 bank has no effect at 4 bpp
    cpu_wr(4'hE, 8'hC0);
    pix_chk("R5 bank3 pix2", 1'b0, 4'd2);
    pix_chk("R5 pix15", 1'b0, 4'd15);
    // R6 banked lookup, upper pixel bits ignored
    cpu_wr(4'hE, 8'h80);
    pix_chk("R6 bank2 pix 1101", 1'b1, 4'b1101);
    pix_chk("R6 bank2 pix 0001", 1'b1, 4'b0001);
    // R8 unselected reads and writes
    @(negedge clk); io_addr = 4'hF; io_cs = 1'b0; io_re = 1'b1;
    #1 chk("R8 cs low read", io_rdata, 8'h00);
    io_cs = 1'b1; io_re = 1'b0;
    #1 chk("R8 re low read", io_rdata, 8'h00);
    io_addr = 4'h3; io_re = 1'b1;
    #1 chk("R8 other addr read", io_rdata, 8'h00);
    io_cs = 1'b0; io_re = 1'b0;
    cpu_wr(4'hF, 8'h07, 1'b0);
    cpu_rd("R8 cs low write dropped", 4'hF);
    cpu_wr(4'h5, 8'hFF);
    cpu_rd("R8 other addr write dropped", 4'hE);
    cpu_rd("R8 other addr write dropped data", 4'hF);
    // R7 write and lookup at the same edge
    cpu_wr(4'hE, 8'h05);
    cpu_wr(4'hF, 8'h02);
    @(negedge clk);
    pix_mode = 1'b0; pix_val = 4'd5;
    io_addr = 4'hF; io_wdata = 8'h09; io_cs = 1'b1; io_we = 1'b1;
    @(negedge clk);
    io_cs = 1'b0; io_we = 1'b0;
    chk("R7 old value same edge", {4'h0, shade_out}, 8'h02);
    m_tbl[5] = 4'h9;
    @(negedge clk);
    chk("R7 new value next edge", {4'h0, shade_out}, 8'h09);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: cpu_wr(4'hE, 8'($urandom));
        1: cpu_wr(4'hF, 8'($urandom));
        2: cpu_rd("R2 R3 random read", 4'($urandom_range(14, 15)));
        default: pix_chk("R5 R6 random lookup", 1'($urandom), 4'($urandom));
      endcase
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule